// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the device-side controller for the command port of a parallel NOR flash. It watches an active-low write strobe that carries a word address and a data byte. It recognises the unlock-prefixed command sequences for word programming, sector erase, block erase and whole-chip erase. It also recognises the single-write commands that suspend and resume an erase. Array contents are not modelled. The block tracks which operation is running, runs each internal operation for a cycle count set by a parameter, and drives a busy output.

While an operation runs, commands are locked out. A sector or block erase still accepts a suspend. After a bounded latency the part reaches a suspended state, and in that state a program may target any address outside the region that was being erased. A later resume continues the erase from where it stopped, so the erase keeps its full length. Chip erase is refused whenever the write-protect input is low.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `mode` is 0 (idle) and `busy` is 0.
- R2: The six-write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 50h selects a sector erase of the 2K-word sector (address bits above bit 10) given in the last write. The same sequence ending in 30h selects a block erase of a 32K-word block (address bits above bit 14). During either erase `mode` is 2 and `busy` is 1, for SECT_CYC or BLK_CYC cycles respectively, then the block returns to idle. Only address bits [10:0] are compared against 555h and 2AAh.
- R3: The same six-write sequence ending in 10h written to 555h starts a chip erase: `mode` is 3 and `busy` is 1 for CHIP_CYC cycles. If `wp_n` is low when the last write completes, the chip erase is ignored and `mode` stays 0.
- R4: Any write that does not match the next expected step of a sequence returns the decoder to its first step, so the rest of that sequence starts nothing. This includes a last write of 10h to an address other than 555h.
- R5: On each write, the address is captured when `we_n` falls and the data when `we_n` rises. The resulting state change shows on `mode` after the second rising clock edge that samples `we_n` high, and not before.
- R6: While a program (`mode` 1) or a chip erase (`mode` 3) runs, every write is ignored, including B0h.
- R7: While a sector or block erase runs, a single write of B0h to any address moves `mode` to 4 (suspending, `busy` 1). After SUSP_CYC cycles, which are bounded by SUSP_MAX, `mode` becomes 5 (suspended, `busy` 0). All other sequences are ignored during the erase and while suspending.
- R8: Across any number of suspends, an erase spends exactly SECT_CYC or BLK_CYC cycles in total with `mode` 2.
- R9: In the suspended state, a write of 30h to any address resumes the erase (`mode` 2, `busy` 1). This applies when no program sequence is partly entered.
- R10: The four-write sequence AAh@555h, 55h@2AAh, A0h@555h, then a write of the data to the target address starts a program. From idle, `mode` is 1 for PROG_CYC cycles. When suspended and the target is outside the suspended sector or block, `mode` is 6 (`busy` 1) for PROG_CYC cycles and then returns to 5. When the target is inside that region, the program is ignored. Erase sequences are ignored while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Active-low write strobe, sampled on the clock |
| addr | input | AW | Word address of the write |
| din | input | 8 | Command or data byte of the write |
| wp_n | input | 1 | Write protect, low blocks chip erase |
| busy | output | 1 | An internal operation is running |
| mode | output | 3 | 0 idle, 1 program, 2 sector/block erase, 3 chip erase, 4 suspending, 5 suspended, 6 program while suspended |

## Verification
The bench builds the block with PROG_CYC 6, SECT_CYC 20, BLK_CYC 30, CHIP_CYC 40 and SUSP_CYC 3 instead of the microsecond-scale defaults. With these values, every operation runs to completion in a few dozen cycles. A program sequence, a suspend and a protected-region attempt fit inside a single erase. The bench can also count every cycle an erase spends in mode 2 before and after a resume, and check that the total equals the configured length.

// File: rtl/nes_pkg.sv
package nes_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_CHIP  = 3'd3,
    M_SWAIT = 3'd4,
    M_SUSP  = 3'd5,
    M_SPROG = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PROG,
    EV_SECT,
    EV_BLK,
    EV_CHIP
  } ev_e;

  localparam logic [7:0]  K_UNLK1  = 8'hAA;
  localparam logic [7:0]  K_UNLK2  = 8'h55;
  localparam logic [7:0]  K_ESETUP = 8'h80;
  localparam logic [7:0]  K_PROG   = 8'hA0;
  localparam logic [7:0]  K_CHIP   = 8'h10;
  localparam logic [7:0]  K_SECT   = 8'h50;
  localparam logic [7:0]  K_BLK    = 8'h30;
  localparam logic [7:0]  K_SUSP   = 8'hB0;
  localparam logic [7:0]  K_RES    = 8'h30;
  localparam logic [10:0] ADR_X    = 11'h555;
  localparam logic [10:0] ADR_Y    = 11'h2AA;

  // A mode counts as busy unless it is idle or fully suspended.
  function automatic logic mode_busy(mode_e m);
    return (m != M_IDLE) && (m != M_SUSP);
  endfunction

  // Two addresses fall in the same region when they agree above bit 'sh'.
  function automatic logic same_region(logic [31:0] a, logic [31:0] b, int unsigned sh);
    return (a >> sh) == (b >> sh);
  endfunction

endpackage

// File: rtl/nes_strobe.sv
module nes_strobe #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          cmd_vld,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data
);
  logic          we_q;
  logic [AW-1:0] a_lat;
  logic          fall_ev, rise_ev;

  assign fall_ev = we_q & ~we_n;
  assign rise_ev = ~we_q & we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      a_lat    <= '0;
      cmd_vld  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      we_q    <= we_n;
      cmd_vld <= rise_ev;
      if (fall_ev) a_lat <= addr;
      if (rise_ev) begin
        cmd_addr <= a_lat;
        cmd_data <= din;
      end
    end
  end

  // R5: the address of a write is the one present at the falling strobe
  assert_addr_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> a_lat == $past(addr));

endmodule

// File: rtl/nes_unlock.sv
module nes_unlock
  import nes_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cmd_vld,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  output ev_e           ev,
  output logic          dec_idle
);
  logic [2:0]  step, step_nx;
  logic        at_x, at_y;

  assign at_x     = cmd_addr[10:0] == ADR_X;
  assign at_y     = cmd_addr[10:0] == ADR_Y;
  assign dec_idle = step == 3'd0;

  always_comb begin
    step_nx = 3'd0;
    ev      = EV_NONE;
    if (en && cmd_vld) begin
      case (step)
        3'd0: if (at_x && cmd_data == K_UNLK1) step_nx = 3'd1;
        3'd1: if (at_y && cmd_data == K_UNLK2) step_nx = 3'd2;
        3'd2: begin
          if (at_x && cmd_data == K_ESETUP) step_nx = 3'd3;
          else if (at_x && cmd_data == K_PROG) step_nx = 3'd6;
        end
        3'd3: if (at_x && cmd_data == K_UNLK1) step_nx = 3'd4;
        3'd4: if (at_y && cmd_data == K_UNLK2) step_nx = 3'd5;
        3'd5: begin
          if (cmd_data == K_CHIP && at_x) ev = EV_CHIP;
          else if (cmd_data == K_SECT) ev = EV_SECT;
          else if (cmd_data == K_BLK) ev = EV_BLK;
        end
        3'd6: ev = EV_PROG;
        default: step_nx = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       step <= 3'd0;
    else if (!en)     step <= 3'd0;
    else if (cmd_vld) step <= step_nx;
  end

  // R4: a byte that no sequence uses sends the decoder back to its start
  assert_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_vld && cmd_data == 8'h00 && step != 3'd6) |=> step == 3'd0);

endmodule

// File: rtl/nes_timer.sv
module nes_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = run && cnt == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  // R8: a paused count keeps its remaining value
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt));

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nes_pkg::*;
#(
  parameter int AW       = 21,
  parameter int SEC_W    = 11,
  parameter int BLK_W    = 15,
  parameter int PROG_CYC = 350,
  parameter int SECT_CYC = 900000,
  parameter int BLK_CYC  = 900000,
  parameter int CHIP_CYC = 2000000,
  parameter int SUSP_CYC = 500,
  parameter int SUSP_MAX = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          wp_n,
  output logic          busy,
  output logic [2:0]    mode
);
  localparam int ERS_MAX = (SECT_CYC > BLK_CYC) ? ((SECT_CYC > CHIP_CYC) ? SECT_CYC : CHIP_CYC)
                                                : ((BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC);
  localparam int AUX_LIM = (PROG_CYC > SUSP_MAX) ? PROG_CYC : SUSP_MAX;
  localparam int CNT_MAX = (ERS_MAX > AUX_LIM) ? ERS_MAX : AUX_LIM;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int SUSP_EFF = (SUSP_CYC > SUSP_MAX) ? SUSP_MAX : SUSP_CYC;
  localparam int NT      = 2;   // timer 0: erase length, timer 1: program / suspend latency

  mode_e         st, st_nx;
  logic          cmd_vld;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  ev_e           ev;
  logic          dec_idle, dec_en;
  logic [AW-1:0] rgn_base;
  logic          rgn_blk, rgn_blk_nx;
  logic [AW-1:0] rgn_base_nx;

  logic [NT-1:0] t_load, t_run, t_last;
  logic [CW-1:0] t_val [NT];

  // named events for the checks
  logic susp_hit, resume_hit, chip_blocked, prog_guarded, in_rgn;

  nes_strobe #(.AW(AW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
    .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  assign dec_en = (st == M_IDLE) || (st == M_SUSP);

  nes_unlock #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .cmd_vld(cmd_vld),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .ev(ev), .dec_idle(dec_idle)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    nes_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load[g]), .load_val(t_val[g]),
      .run(t_run[g]), .last(t_last[g])
    );
  end

  assign in_rgn = same_region(32'(cmd_addr), 32'(rgn_base),
                              rgn_blk ? BLK_W : SEC_W);
  assign susp_hit     = (st == M_ERASE) && cmd_vld && cmd_data == K_SUSP && !t_last[0];
  assign resume_hit   = (st == M_SUSP) && cmd_vld && cmd_data == K_RES && dec_idle;
  assign chip_blocked = (st == M_IDLE) && ev == EV_CHIP && !wp_n;
  assign prog_guarded = (st == M_SUSP) && ev == EV_PROG && in_rgn;

  assign t_run[0] = (st == M_ERASE) || (st == M_CHIP);
  assign t_run[1] = (st == M_PROG) || (st == M_SWAIT) || (st == M_SPROG);

  always_comb begin
    st_nx       = st;
    t_load      = '0;
    t_val[0]    = CW'(SECT_CYC);
    t_val[1]    = CW'(PROG_CYC);
    rgn_base_nx = rgn_base;
    rgn_blk_nx  = rgn_blk;
    case (st)
      M_IDLE: begin
        case (ev)
          EV_PROG: begin st_nx = M_PROG; t_load[1] = 1'b1; end
          EV_SECT: begin
            st_nx = M_ERASE; t_load[0] = 1'b1;
            rgn_base_nx = cmd_addr; rgn_blk_nx = 1'b0;
          end
          EV_BLK: begin
            st_nx = M_ERASE; t_load[0] = 1'b1; t_val[0] = CW'(BLK_CYC);
            rgn_base_nx = cmd_addr; rgn_blk_nx = 1'b1;
          end
          EV_CHIP: if (wp_n) begin
            st_nx = M_CHIP; t_load[0] = 1'b1; t_val[0] = CW'(CHIP_CYC);
          end
          default: ;
        endcase
      end
      M_PROG:  if (t_last[1]) st_nx = M_IDLE;
      M_CHIP:  if (t_last[0]) st_nx = M_IDLE;
      M_ERASE: begin
        if (t_last[0]) st_nx = M_IDLE;
        else if (susp_hit) begin
          st_nx = M_SWAIT; t_load[1] = 1'b1; t_val[1] = CW'(SUSP_EFF);
        end
      end
      M_SWAIT: if (t_last[1]) st_nx = M_SUSP;
      M_SUSP: begin
        if (resume_hit) st_nx = M_ERASE;
        else if (ev == EV_PROG && !in_rgn) begin
          st_nx = M_SPROG; t_load[1] = 1'b1;
        end
      end
      M_SPROG: if (t_last[1]) st_nx = M_SUSP;
      default: st_nx = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= M_IDLE;
      rgn_base <= '0;
      rgn_blk  <= 1'b0;
    end else begin
      st       <= st_nx;
      rgn_base <= rgn_base_nx;
      rgn_blk  <= rgn_blk_nx;
    end
  end

  assign mode = st;
  assign busy = mode_busy(st);

  // R3: chip erase refused under write protect
  assert_chip_wp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_blocked |=> mode == 3'd0);

  // R6: program and chip erase only ever end, never change to another mode
  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_PROG || st == M_CHIP) |=> (mode == $past(mode) || mode == 3'd0));

  // R7: a suspend request leaves the erase and stays busy
  assert_susp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_hit |=> (mode == 3'd4 && busy));

  // R9: resume goes straight back to erasing
  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_hit |=> (mode == 3'd2 && busy));

  // R10: a program aimed at the suspended region leaves the part suspended
  assert_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_guarded |=> (mode == 3'd5 && !busy));

endmodule

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          wp_n = 1'b1;
  logic          busy;
  logic [2:0]    mode;

  int n_cmp = 0;
  int n_bad = 0;
  int ers_cyc = 0;

  typedef struct {
    logic [2:0] m;
    logic       b;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  nor_erase_seq #(
    .AW(AW), .SEC_W(11), .BLK_W(15), .PROG_CYC(6), .SECT_CYC(20),
    .BLK_CYC(30), .CHIP_CYC(40), .SUSP_CYC(3), .SUSP_MAX(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
    .wp_n(wp_n), .busy(busy), .mode(mode)
  );

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (mode !== e.m || busy !== e.b) begin
          n_bad++;
          $display("FAIL %s: mode=%0d busy=%0b expected mode=%0d busy=%0b",
                   e.tag, mode, busy, e.m, e.b);
        end
      end
    end
  end

  always @(negedge clk) if (mode == 3'd2) ers_cyc++;

  task automatic expect_st(input logic [2:0] m, input logic b, input string tag);
    exp_t e;
    e.m = m; e.b = b; e.tag = tag;
    exp_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic chk_val(input int act, input int expv, input string tag);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wait_n(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // one write: strobe low, data, strobe high; ends where the effect is visible
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; we_n = 1'b0;
    @(negedge clk); din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic erase_head();
    wr(21'h555, 8'hAA); wr(21'h2AA, 8'h55); wr(21'h555, 8'h80);
    wr(21'h555, 8'hAA); wr(21'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(21'h555, 8'hAA); wr(21'h2AA, 8'h55); wr(21'h555, 8'hA0); wr(a, d);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    expect_st(3'd0, 1'b0, "R1 reset");

    // R2 sector erase, R8 total length
    ers_cyc = 0;
    erase_head(); wr(21'h01234, 8'h50);
    expect_st(3'd2, 1'b1, "R2 sector start");
    wait_n(19); expect_st(3'd2, 1'b1, "R2 sector last cycle");
    wait_n(1);  expect_st(3'd0, 1'b0, "R2 sector done");
    chk_val(ers_cyc, 20, "R8 sector length");

    // R2 block erase
    erase_head(); wr(21'h48000, 8'h30);
    expect_st(3'd2, 1'b1, "R2 block start");
    wait_n(29); expect_st(3'd2, 1'b1, "R2 block last cycle");
    wait_n(1);  expect_st(3'd0, 1'b0, "R2 block done");

    // R3 chip erase with protect, then without; R6 suspend ignored
    wp_n = 1'b0;
    erase_head(); wr(21'h555, 8'h10);
    expect_st(3'd0, 1'b0, "R3 chip blocked by wp_n");
    wp_n = 1'b1;
    erase_head(); wr(21'h555, 8'h10);
    expect_st(3'd3, 1'b1, "R3 chip start");
    wr(21'h00000, 8'hB0);
    expect_st(3'd3, 1'b1, "R6 suspend ignored in chip erase");
    wait_n(35); expect_st(3'd3, 1'b1, "R3 chip last cycle");
    wait_n(1);  expect_st(3'd0, 1'b0, "R3 chip done");

    // R4 mismatches
    erase_head(); wr(21'h00000, 8'h10);
    expect_st(3'd0, 1'b0, "R4 chip at wrong address");
    wr(21'h555, 8'hAA); wr(21'h2AA, 8'h55); wr(21'h555, 8'h80);
    wr(21'h555, 8'hAA); wr(21'h123, 8'h55); wr(21'h01800, 8'h50);
    expect_st(3'd0, 1'b0, "R4 broken unlock");

    // R5 address at falling strobe, timing; then suspend/resume on sector 3
    ers_cyc = 0;
    erase_head();
    addr = 21'h01800; we_n = 1'b0;
    @(negedge clk); din = 8'h50; addr = 21'h09000;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    expect_st(3'd0, 1'b0, "R5 no effect before second edge");
    @(negedge clk);
    expect_st(3'd2, 1'b1, "R5 erase visible at second edge");
    wr(21'h1F0F0, 8'hB0);
    expect_st(3'd4, 1'b1, "R7 suspending");
    wait_n(2); expect_st(3'd4, 1'b1, "R7 still suspending");
    wait_n(1); expect_st(3'd5, 1'b0, "R7 suspended");
    prog(21'h01A00, 8'h5A);
    expect_st(3'd5, 1'b0, "R10 program into suspended sector ignored (R5 fall address)");
    erase_head(); wr(21'h10000, 8'h50);
    expect_st(3'd5, 1'b0, "R10 erase ignored while suspended");
    prog(21'h09000, 8'h5A);
    expect_st(3'd6, 1'b1, "R10 program outside region");
    wait_n(5); expect_st(3'd6, 1'b1, "R10 program last cycle");
    wait_n(1); expect_st(3'd5, 1'b0, "R10 back to suspended");
    wr(21'h07777, 8'h30);
    expect_st(3'd2, 1'b1, "R9 resume");
    wait_n(15); expect_st(3'd2, 1'b1, "R8 resumed last cycle");
    wait_n(1);  expect_st(3'd0, 1'b0, "R8 resumed erase done");
    chk_val(ers_cyc, 20, "R8 sector length across suspend");

    // block erase: program ignored during erase, block-granular guard
    ers_cyc = 0;
    erase_head(); wr(21'h48000, 8'h30);
    prog(21'h00100, 8'h12);
    expect_st(3'd2, 1'b1, "R7 program ignored during erase");
    wr(21'h00000, 8'hB0);
    wait_n(3); expect_st(3'd5, 1'b0, "R7 block suspended");
    prog(21'h4A000, 8'h12);
    expect_st(3'd5, 1'b0, "R10 program inside suspended block ignored");
    wr(21'h00ABC, 8'h30);
    expect_st(3'd2, 1'b1, "R9 block resume");
    wait_n(10); expect_st(3'd0, 1'b0, "R8 block done");
    chk_val(ers_cyc, 30, "R8 block length across suspend");

    // R10 program from idle, R6 lockout during program
    wr(21'h00000, 8'hB0);
    expect_st(3'd0, 1'b0, "R7 suspend ignored when idle");
    prog(21'h12345, 8'h77);
    expect_st(3'd1, 1'b1, "R10 program start");
    wr(21'h00000, 8'hB0);
    expect_st(3'd1, 1'b1, "R6 suspend ignored in program");
    wait_n(1); expect_st(3'd1, 1'b1, "R10 program last cycle");
    wait_n(1); expect_st(3'd0, 1'b0, "R10 program done");

    wait_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule